// File: doc/BRIEF.md
# Continuous-Convert ADC Sequencer

This block runs an external eight-input successive-approximation converter in an endless loop. It derives a slow conversion clock from the fast system clock. That clock is always below the converter's 1280 kHz ceiling. Each step of the sequence takes one period of that clock.

A conversion runs as follows. The selected channel address is presented and an address-latch pulse is issued, followed by a start pulse. The sequencer then follows the converter's end-of-conversion line as it falls and later rises. It then drives the output enable, takes the converter's byte into a holding register and flags it with a one-cycle done strobe. The next conversion then begins on its own.

The channel comes from a 3-bit static select, typically from switches. The held byte stays constant between results, so it can feed a display or a reconstruction path directly. A bounded wait protects against a converter whose low phase of end-of-conversion is too short to be seen.

Top module: `adc_loop_ctrl`

## Requirements
- R1: `chan_sel_i` is sampled at the system-clock edge that begins each address-latch step. It appears on `addr_o`, with bit 2 as the most significant address line and bit 0 as the least. `addr_o` stays unchanged from the end of the address-latch step until the next address-latch step begins.
- R2: Every conversion begins with `ale_o` high for exactly one conversion-clock period. `start_o` follows immediately, also high for exactly one period. The two are never high together.
- R3: `eoc_i` is resynchronised through two system-clock flops. `oe_o` does not rise while `eoc_i` is low after a fall. `oe_o` rises only after `eoc_i` has returned high.
- R4: `conv_clk_o` has 50 % duty. Its period, counted in system cycles, is the smallest even integer strictly greater than SYS_HZ / CONV_MAX_HZ (4 cycles at 4 MHz, 20 cycles at 25.175 MHz).
- R5: `oe_o` is high for exactly two conversion-clock periods per conversion: the read step and the latch step. `done_o` only occurs while `oe_o` is high.
- R6: `data_o` takes `adc_data_i` only at the edge that enters the latch step, which is one period after `oe_o` rises. `adc_data_i` is ignored at every other time, and `data_o` holds its value between results.
- R7: `done_o` is high for exactly one system cycle per conversion. It rises at the same edge at which `data_o` takes its new value.
- R8: The conversions run without any trigger. The next `ale_o` rises at the same edge at which `oe_o` falls, which is one period after `done_o`.
- R9: If the resynchronised `eoc_i` has not been seen low within EOC_WAIT conversion-clock periods after `start_o` falls, the sequencer moves on and waits for it to be high. With `eoc_i` held high throughout, `oe_o` rises exactly (EOC_WAIT+1) periods after `start_o` falls.
- R10: While `rst_ni` is low, the following outputs are all 0: `ale_o`, `start_o`, `oe_o`, `done_o`, `conv_clk_o`, `addr_o` and `data_o`. After release, the first `ale_o` follows without any trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_sel_i | input | 3 | Channel select from switches |
| eoc_i | input | 1 | Converter end-of-conversion line (asynchronous) |
| adc_data_i | input | 8 | Converter data bus |
| conv_clk_o | output | 1 | Divided clock for the converter |
| addr_o | output | 3 | Channel address lines to the converter |
| ale_o | output | 1 | Address-latch pulse |
| start_o | output | 1 | Start-of-conversion pulse |
| oe_o | output | 1 | Converter output enable |
| data_o | output | 8 | Held conversion result |
| done_o | output | 1 | One-cycle strobe for a new result |

## Verification
Two events share one step here. The latch step captures the previous result, and the channel for the next conversion is taken on the edge that leaves that step. The bench changes both the channel select and the converter bus during that step, just after `done_o`. It then judges that `data_o` keeps the captured byte and that the next conversion reports the new address. A second overlap is the bounded wait expiring while the end-of-conversion line is still high. The bench provokes this with vectors whose converter never drops the line, and it requires the read step to start exactly EOC_WAIT+1 periods after start.

// File: rtl/adc_loop_pkg.sv
`timescale 1ns/1ps
package adc_loop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALE,
    ST_START,
    ST_WAIT_LO,
    ST_WAIT_HI,
    ST_READ,
    ST_LATCH
  } seq_state_e;

  // smallest even cycle count strictly above sys/max
  function automatic int conv_period(input int sys_hz, input int max_hz);
    int p;
    p = sys_hz / max_hz + 1;
    if ((p % 2) != 0) p = p + 1;
    return p;
  endfunction

endpackage

// File: rtl/adc_clk_div.sv
`timescale 1ns/1ps
module adc_clk_div #(
  parameter int HALF = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic conv_clk_o,
  output logic tick_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // tick coincides with the rising edge of the converter clock
  assign tick_o     = (cnt_q == LAST) && !clk_q;
  assign conv_clk_o = clk_q;
endmodule

// File: rtl/adc_eoc_sync.sv
`timescale 1ns/1ps
module adc_eoc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-2:0], async_i};
  end

  assign sync_o = sh_q[STAGES-1];
endmodule

// File: rtl/adc_seq_fsm.sv
`timescale 1ns/1ps
module adc_seq_fsm
  import adc_loop_pkg::*;
#(
  parameter int CH_W     = 3,
  parameter int EOC_WAIT = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            eoc_i,
  input  logic [CH_W-1:0] chan_i,
  output logic [CH_W-1:0] addr_o,
  output logic            ale_o,
  output logic            start_o,
  output logic            oe_o,
  output logic            cap_o
);
  localparam int TW = $clog2(EOC_WAIT + 1);
  localparam logic [TW-1:0] T_LAST = TW'(EOC_WAIT - 1);

  seq_state_e      st_q;
  logic [TW-1:0]   tcnt_q;
  logic [CH_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      tcnt_q <= '0;
      addr_q <= '0;
    end else if (tick_i) begin
      unique case (st_q)
        ST_IDLE: begin
          st_q   <= ST_ALE;
          addr_q <= chan_i;
        end
        ST_ALE:   st_q <= ST_START;
        ST_START: begin
          st_q   <= ST_WAIT_LO;
          tcnt_q <= '0;
        end
        ST_WAIT_LO: begin
          // bounded wait: a missed low phase must not stall the loop
          if (!eoc_i || tcnt_q == T_LAST) st_q <= ST_WAIT_HI;
          else                            tcnt_q <= tcnt_q + 1'b1;
        end
        ST_WAIT_HI: if (eoc_i) st_q <= ST_READ;
        ST_READ:  st_q <= ST_LATCH;
        ST_LATCH: begin
          st_q   <= ST_ALE;
          addr_q <= chan_i;
        end
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign addr_o  = addr_q;
  assign ale_o   = (st_q == ST_ALE);
  assign start_o = (st_q == ST_START);
  assign oe_o    = (st_q == ST_READ) || (st_q == ST_LATCH);
  assign cap_o   = tick_i && (st_q == ST_READ);
endmodule

// File: rtl/adc_result_reg.sv
`timescale 1ns/1ps
module adc_result_reg #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o,
  output logic          done_o
);
  logic [DW-1:0] q_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q    <= '0;
      done_q <= 1'b0;
    end else begin
      if (cap_i) q_q <= d_i;
      done_q <= cap_i;
    end
  end

  assign q_o    = q_q;
  assign done_o = done_q;
endmodule

// File: rtl/adc_loop_ctrl.sv
`timescale 1ns/1ps
module adc_loop_ctrl
  import adc_loop_pkg::*;
#(
  parameter int SYS_HZ      = 25_175_000,
  parameter int CONV_MAX_HZ = 1_280_000,
  parameter int DW          = 8,
  parameter int CH_W        = 3,
  parameter int EOC_WAIT    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CH_W-1:0] chan_sel_i,
  input  logic            eoc_i,
  input  logic [DW-1:0]   adc_data_i,
  output logic            conv_clk_o,
  output logic [CH_W-1:0] addr_o,
  output logic            ale_o,
  output logic            start_o,
  output logic            oe_o,
  output logic [DW-1:0]   data_o,
  output logic            done_o
);
  localparam int PERIOD = conv_period(SYS_HZ, CONV_MAX_HZ);
  localparam int HALF   = PERIOD / 2;

  logic tick;
  logic eoc_s;
  logic cap;

  adc_clk_div #(.HALF(HALF)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .conv_clk_o(conv_clk_o),
    .tick_o    (tick)
  );

  adc_eoc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(eoc_i),
    .sync_o (eoc_s)
  );

  adc_seq_fsm #(.CH_W(CH_W), .EOC_WAIT(EOC_WAIT)) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .eoc_i  (eoc_s),
    .chan_i (chan_sel_i),
    .addr_o (addr_o),
    .ale_o  (ale_o),
    .start_o(start_o),
    .oe_o   (oe_o),
    .cap_o  (cap)
  );

  adc_result_reg #(.DW(DW)) u_res (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap_i (cap),
    .d_i   (adc_data_i),
    .q_o   (data_o),
    .done_o(done_o)
  );
endmodule

// File: rtl/adc_loop_ctrl_chk.sv
`timescale 1ns/1ps
module adc_loop_ctrl_chk #(
  parameter int DW   = 8,
  parameter int CH_W = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            eoc_i,
  input logic [CH_W-1:0] addr_o,
  input logic            ale_o,
  input logic            start_o,
  input logic            oe_o,
  input logic [DW-1:0]   data_o,
  input logic            done_o
);
  a_r1_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o || oe_o) |-> $stable(addr_o));

  a_r2_start_follows_ale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ale_o) |-> start_o);

  a_r2_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ale_o && start_o));

  a_r3_oe_after_eoc_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> eoc_i);

  a_r5_done_under_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> oe_o);

  a_r6_data_moves_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> done_o);

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_o) |-> ale_o);
endmodule

bind adc_loop_ctrl adc_loop_ctrl_chk #(.DW(DW), .CH_W(CH_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .eoc_i  (eoc_i),
  .addr_o (addr_o),
  .ale_o  (ale_o),
  .start_o(start_o),
  .oe_o   (oe_o),
  .data_o (data_o),
  .done_o (done_o)
);

// File: tb/adc_loop_ctrl_bench.sv
`timescale 1ns/1ps
module adc_loop_ctrl_bench;
  localparam int SYS_HZ   = 4_000_000;
  localparam int MAX_HZ   = 1_280_000;
  localparam int EOC_WAIT = 6;
  localparam int TCK      = 10;
  // R4: smallest even count strictly above SYS/MAX
  localparam int P_RAW    = SYS_HZ / MAX_HZ + 1;
  localparam int PER      = (P_RAW % 2 != 0) ? P_RAW + 1 : P_RAW;
  localparam int PER_NS   = PER * TCK;
  localparam int NV       = 8;

  // {chan[19:17], data[16:9], drop[8], lo[7:4], hi[3:0]}
  localparam logic [19:0] VEC [NV] = '{
    {3'd0, 8'h00, 1'b1, 4'd1, 4'd3},
    {3'd1, 8'h01, 1'b1, 4'd2, 4'd2},
    {3'd5, 8'h80, 1'b1, 4'd1, 4'd4},
    {3'd7, 8'hFF, 1'b0, 4'd0, 4'd0},
    {3'd2, 8'hC0, 1'b1, 4'd2, 4'd3},
    {3'd4, 8'h5A, 1'b1, 4'd1, 4'd2},
    {3'd3, 8'hA5, 1'b0, 4'd0, 4'd0},
    {3'd6, 8'h3C, 1'b1, 4'd2, 4'd5}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] chan_sel_i = 3'd0;
  logic       eoc_i = 1'b1;
  logic [7:0] bus_val = 8'h00;
  logic [7:0] adc_data_i;
  logic       conv_clk_o, ale_o, start_o, oe_o, done_o;
  logic [2:0] addr_o;
  logic [7:0] data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(TCK/2) clk_i = ~clk_i;

  // bus carries the result only under OE, garbage otherwise
  assign adc_data_i = oe_o ? bus_val : ~bus_val;

  adc_loop_ctrl #(
    .SYS_HZ(SYS_HZ), .CONV_MAX_HZ(MAX_HZ), .EOC_WAIT(EOC_WAIT)
  ) u_adc_loop_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .chan_sel_i(chan_sel_i), .eoc_i(eoc_i),
    .adc_data_i(adc_data_i), .conv_clk_o(conv_clk_o), .addr_o(addr_o),
    .ale_o(ale_o), .start_o(start_o), .oe_o(oe_o), .data_o(data_o),
    .done_o(done_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(150_000 * TCK);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
    end
  end

  initial begin
    longint t_ale_r, t_ale_f, t_st_f, t_oe_r, t_done, t_oe_f, t_eoc;
    logic [7:0] prev;
    prev = 8'h00;
    chan_sel_i = VEC[0][19:17];
    bus_val    = VEC[0][16:9];
    #(3 * TCK + 2);
    // R10 reset state
    chk("R10 ale",  ale_o, 0);
    chk("R10 start", start_o, 0);
    chk("R10 oe",   oe_o, 0);
    chk("R10 done", done_o, 0);
    chk("R10 cclk", conv_clk_o, 0);
    chk("R10 data", data_o, 0);
    chk("R10 addr", addr_o, 0);
    rst_ni = 1'b1;
    @(posedge ale_o); t_ale_r = $time;

    for (int i = 0; i < NV; i++) begin
      logic [2:0] ch;  logic [7:0] dv;  logic drop;  int lo, hi;
      ch = VEC[i][19:17]; dv = VEC[i][16:9]; drop = VEC[i][8];
      lo = int'(VEC[i][7:4]); hi = int'(VEC[i][3:0]);
      bus_val = dv;
      @(negedge ale_o); t_ale_f = $time;
      chk("R2 ale width", t_ale_f - t_ale_r, PER_NS);
      #1;
      chk("R2 start after ale", start_o, 1);
      chk("R1 addr", addr_o, ch);
      @(negedge start_o); t_st_f = $time;
      chk("R2 start width", t_st_f - t_ale_f, PER_NS);
      #1;
      chk("R6 data held", data_o, prev);
      if (drop) begin
        repeat (lo) @(posedge conv_clk_o);
        #1 eoc_i = 1'b0;
        repeat (hi) @(posedge conv_clk_o);
        #1;
        chk("R3 no oe while eoc low", oe_o, 0);
        eoc_i = 1'b1; t_eoc = $time;
        @(posedge oe_o); t_oe_r = $time;
        chk("R3 oe after eoc high", (t_oe_r - t_eoc) >= 2 * TCK, 1);
      end else begin
        @(posedge oe_o); t_oe_r = $time;
        chk("R9 timeout delay", t_oe_r - t_st_f, (EOC_WAIT + 1) * PER_NS);
      end
      @(posedge done_o); t_done = $time;
      chk("R6 capture point", t_done - t_oe_r, PER_NS);
      #1;
      chk("R6 data", data_o, dv);
      chk("R5 oe at done", oe_o, 1);
      chk("R1 addr during read", addr_o, ch);
      // change channel and bus in the latch step
      chan_sel_i = VEC[(i + 1) % NV][19:17];
      bus_val    = ~dv;
      @(posedge clk_i); #1;
      chk("R7 done one cycle", done_o, 0);
      @(negedge oe_o); t_oe_f = $time;
      chk("R5 oe width", t_oe_f - t_oe_r, 2 * PER_NS);
      chk("R8 restart", t_oe_f - t_done, PER_NS);
      #1;
      chk("R8 ale high", ale_o, 1);
      chk("R6 bus ignored", data_o, dv);
      prev = dv;
      t_ale_r = t_oe_f;
    end

    // mid-conversion reset
    @(negedge start_o); #(2 * TCK + 1);
    rst_ni = 1'b0; eoc_i = 1'b1;
    #2;
    chk("R10 mid ale", ale_o, 0);
    chk("R10 mid start", start_o, 0);
    chk("R10 mid oe", oe_o, 0);
    chk("R10 mid data", data_o, 0);
    chk("R10 mid cclk", conv_clk_o, 0);
    #(2 * TCK);
    rst_ni = 1'b1;
    begin
      longint a, b, c;
      @(posedge conv_clk_o); a = $time;
      #1 chk("R10 ale after release", ale_o, 1);
      @(negedge conv_clk_o); b = $time;
      @(posedge conv_clk_o); c = $time;
      chk("R4 high time", b - a, PER_NS / 2);
      chk("R4 period", c - a, PER_NS);
    end
    finished = 1;
    summary();
  end
endmodule